// File: doc/BRIEF.md
# Domain and Access Permission Checker

This block decides whether a memory access that has already been translated may go ahead. It takes the attributes decoded from the matching translation descriptor: the domain number, the two permission bits and the execute-never flag. It also takes the kind of access, the privilege of the requester and the 32-bit domain control word. One cycle later it either grants the access or reports a fault. The fault carries a code that separates domain faults, permission faults and execute-never faults, and it names the domain that caused it.

Each of the sixteen domains has a two-bit mode field in the control word. A domain can refuse everything, or it can grant everything whatever the descriptor says. Only in the remaining mode are the execute-never flag and the descriptor permission bits looked at. The fault indication is meant to drive the processor's exception logic directly. Translation, memory attributes and vectoring are left to neighbouring blocks.

Top module: `acc_chk_top`

## Requirements
- R1: While rst_ni is low, allow_o and fault_o are 0, fault_code_o is 0 and fault_dom_o is 0.
- R2: The mode of domain d is read from dacr_i bits [2d+1:2d]. Mode 2'b00 denies every access with fault code 1 (domain fault).
- R3: Mode 2'b10 is reserved and behaves exactly like 2'b00 (fault code 1).
- R4: Mode 2'b11 grants every access, ignoring ap_i and xn_i.
- R5: Mode 2'b01 checks ap_i: 2'b00 no access; 2'b01 privileged read/write only; 2'b10 privileged read/write, unprivileged read only; 2'b11 read/write for all. A failed check gives fault code 2 (permission fault). priv_i=1 means privileged.
- R6: In mode 2'b01, an instruction fetch with xn_i=1 faults with code 3. Data accesses to the same region are checked only against ap_i.
- R7: acc_type_i encodes 2'b00 read, 2'b01 write, 2'b10 instruction fetch, and 2'b11 is treated as a fetch. A fetch needs read permission.
- R8: Checks are applied in a fixed order: domain deny (code 1), then execute-never (code 3), then permissions (code 2). Only the first failure is reported. A granted access reports code 0.
- R9: The result appears one cycle after valid_i. Each valid input gives exactly one cycle of either allow_o or fault_o, never both. A cycle without valid_i gives neither, and fault_code_o is 0 in that cycle.
- R10: On a fault, fault_dom_o carries the domain number of the faulting access. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An access is presented this cycle |
| domain_i | input | 4 | Domain named by the descriptor |
| ap_i | input | 2 | Descriptor permission bits |
| xn_i | input | 1 | Descriptor execute-never flag |
| acc_type_i | input | 2 | Access kind: read, write or fetch |
| priv_i | input | 1 | 1 for a privileged requester |
| dacr_i | input | 32 | Domain control word, two bits per domain |
| allow_o | output | 1 | Access granted (one-cycle pulse) |
| fault_o | output | 1 | Access refused (one-cycle pulse) |
| fault_code_o | output | 2 | 0 none, 1 domain, 2 permission, 3 execute-never |
| fault_dom_o | output | 4 | Domain of the faulting access |

## Verification
The bench builds the block with its default of sixteen domains. That makes the lowest and highest mode fields of the control word (domains 0 and 15) reachable, and each table row fills every other domain with a contrasting mode, so a wrong field selection changes the result. The vector table pairs each domain mode with permission, privilege, execute-never and access-kind combinations. These cover every fault code and each step of the check order. Directed tests then cover back-to-back accesses, idle cycles between accesses, and a reset that arrives while a result is due.

// File: rtl/acc_chk_pkg.sv
package acc_chk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    DM_DENY  = 2'b00,
    DM_CHECK = 2'b01,
    DM_ALL   = 2'b11
  } dmode_e;

  typedef enum logic [1:0] {
    FC_NONE   = 2'd0,
    FC_DOMAIN = 2'd1,
    FC_PERM   = 2'd2,
    FC_XN     = 2'd3
  } fcode_e;

  localparam int unsigned DMODE_W = 2;

endpackage

// File: rtl/dom_mode_dec.sv
module dom_mode_dec
  import acc_chk_pkg::*;
#(
  parameter int unsigned NUM_DOM = 16,
  localparam int unsigned DOM_W  = $clog2(NUM_DOM),
  localparam int unsigned CTL_W  = DMODE_W * NUM_DOM
) (
  input  logic [CTL_W-1:0] ctl_i,
  input  logic [DOM_W-1:0] dom_i,
  output dmode_e           mode_o
);

  logic [DMODE_W-1:0] fld [NUM_DOM];

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_fld
    assign fld[d] = ctl_i[DMODE_W*d +: DMODE_W];
  end

  logic [DMODE_W-1:0] sel;
  assign sel = fld[dom_i];

  // reserved encoding 2'b10 folds into deny
  always_comb begin
    unique case (sel)
      2'b01:   mode_o = DM_CHECK;
      2'b11:   mode_o = DM_ALL;
      default: mode_o = DM_DENY;
    endcase
  end

endmodule

// File: rtl/perm_eval.sv
module perm_eval (
  input  logic [1:0] ap_i,
  input  logic       priv_i,
  input  logic       is_write_i,
  output logic       ok_o
);

  always_comb begin
    unique case (ap_i)
      2'b00: ok_o = 1'b0;
      2'b01: ok_o = priv_i;
      2'b10: ok_o = priv_i | ~is_write_i;
      2'b11: ok_o = 1'b1;
      default: ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/fault_resolve.sv
module fault_resolve
  import acc_chk_pkg::*;
(
  input  dmode_e mode_i,
  input  logic   xn_i,
  input  logic   is_fetch_i,
  input  logic   perm_ok_i,
  output fcode_e code_o
);

  always_comb begin
    if (mode_i == DM_DENY)          code_o = FC_DOMAIN;
    else if (mode_i == DM_ALL)      code_o = FC_NONE;
    else if (xn_i && is_fetch_i)    code_o = FC_XN;
    else if (!perm_ok_i)            code_o = FC_PERM;
    else                            code_o = FC_NONE;
  end

endmodule

// File: rtl/acc_chk_top.sv
module acc_chk_top
  import acc_chk_pkg::*;
#(
  parameter int unsigned NUM_DOM = 16,
  localparam int unsigned DOM_W  = $clog2(NUM_DOM),
  localparam int unsigned CTL_W  = DMODE_W * NUM_DOM
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [DOM_W-1:0] domain_i,
  input  logic [1:0]       ap_i,
  input  logic             xn_i,
  input  logic [1:0]       acc_type_i,
  input  logic             priv_i,
  input  logic [CTL_W-1:0] dacr_i,
  output logic             allow_o,
  output logic             fault_o,
  output logic [1:0]       fault_code_o,
  output logic [DOM_W-1:0] fault_dom_o
);

  dmode_e mode;
  logic   perm_ok;
  fcode_e code;
  logic   is_fetch, is_write;

  // reserved access kind counts as a fetch
  assign is_fetch = acc_type_i[1];
  assign is_write = (acc_type_i == ACC_WRITE);

  dom_mode_dec #(.NUM_DOM(NUM_DOM)) u_mode (
    .ctl_i  (dacr_i),
    .dom_i  (domain_i),
    .mode_o (mode)
  );

  perm_eval u_perm (
    .ap_i       (ap_i),
    .priv_i     (priv_i),
    .is_write_i (is_write),
    .ok_o       (perm_ok)
  );

  fault_resolve u_res (
    .mode_i     (mode),
    .xn_i       (xn_i),
    .is_fetch_i (is_fetch),
    .perm_ok_i  (perm_ok),
    .code_o     (code)
  );

  logic hit_fault;
  assign hit_fault = (code != FC_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      allow_o      <= 1'b0;
      fault_o      <= 1'b0;
      fault_code_o <= FC_NONE;
      fault_dom_o  <= '0;
    end else begin
      allow_o      <= valid_i & ~hit_fault;
      fault_o      <= valid_i & hit_fault;
      fault_code_o <= valid_i ? code : FC_NONE;
      fault_dom_o  <= (valid_i && hit_fault) ? domain_i : '0;
    end
  end

endmodule

// File: rtl/acc_chk_sva.sv
module acc_chk_sva #(
  parameter int unsigned NUM_DOM = 16,
  localparam int unsigned DOM_W  = $clog2(NUM_DOM),
  localparam int unsigned CTL_W  = 2 * NUM_DOM
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [DOM_W-1:0] domain_i,
  input logic [1:0]       ap_i,
  input logic             xn_i,
  input logic [1:0]       acc_type_i,
  input logic             priv_i,
  input logic [CTL_W-1:0] dacr_i,
  input logic             allow_o,
  input logic             fault_o,
  input logic [1:0]       fault_code_o,
  input logic [DOM_W-1:0] fault_dom_o
);

  logic [1:0] fld;
  assign fld = dacr_i[2*domain_i +: 2];

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(allow_o && fault_o));

  a_r9_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (allow_o ^ fault_o));

  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!allow_o && !fault_o && fault_code_o == 2'd0));

  a_r2_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fld == 2'b00) |=> (fault_o && fault_code_o == 2'd1));

  a_r3_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fld == 2'b10) |=> (fault_o && fault_code_o == 2'd1));

  a_r4_allow_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fld == 2'b11) |=> allow_o);

  a_r5_full_rw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fld == 2'b01 && ap_i == 2'b11 && !xn_i) |=> allow_o);

  a_r5_user_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fld == 2'b01 && ap_i == 2'b10 && !priv_i && acc_type_i == 2'b01)
    |=> (fault_code_o == 2'd2));

  a_r6_xn_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fld == 2'b01 && xn_i && acc_type_i[1]) |=> (fault_code_o == 2'd3));

  a_r8_code_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_code_o != 2'd0));

  a_r8_code_allow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allow_o |-> (fault_code_o == 2'd0));

  a_r10_dom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (fault_dom_o == (fault_o ? $past(domain_i) : '0)));

endmodule

bind acc_chk_top acc_chk_sva #(.NUM_DOM(NUM_DOM)) u_acc_chk_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .domain_i     (domain_i),
  .ap_i         (ap_i),
  .xn_i         (xn_i),
  .acc_type_i   (acc_type_i),
  .priv_i       (priv_i),
  .dacr_i       (dacr_i),
  .allow_o      (allow_o),
  .fault_o      (fault_o),
  .fault_code_o (fault_code_o),
  .fault_dom_o  (fault_dom_o)
);

// File: tb/acc_chk_top_tb_top.sv
module acc_chk_top_tb_top;

  localparam int unsigned NUM_DOM = 16;
  localparam int unsigned DOM_W   = $clog2(NUM_DOM);
  localparam int unsigned CTL_W   = 2 * NUM_DOM;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [DOM_W-1:0] domain_i = '0;
  logic [1:0]       ap_i = '0;
  logic             xn_i = 1'b0;
  logic [1:0]       acc_type_i = '0;
  logic             priv_i = 1'b0;
  logic [CTL_W-1:0] dacr_i = '0;
  logic             allow_o, fault_o;
  logic [1:0]       fault_code_o;
  logic [DOM_W-1:0] fault_dom_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  acc_chk_top #(.NUM_DOM(NUM_DOM)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .domain_i     (domain_i),
    .ap_i         (ap_i),
    .xn_i         (xn_i),
    .acc_type_i   (acc_type_i),
    .priv_i       (priv_i),
    .dacr_i       (dacr_i),
    .allow_o      (allow_o),
    .fault_o      (fault_o),
    .fault_code_o (fault_code_o),
    .fault_dom_o  (fault_dom_o)
  );

  typedef struct packed {
    logic [3:0] dom;
    logic [1:0] mode;
    logic [1:0] other;
    logic [1:0] ap;
    logic       xn;
    logic [1:0] acc;
    logic       priv;
    logic [1:0] code;
  } vec_t;

  // acc: 0 read, 1 write, 2 fetch, 3 reserved
  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{4'd3,  2'b01, 2'b11, 2'b11, 1'b0, 2'd1, 1'b0, 2'd0}, // R5 full rw
    '{4'd3,  2'b00, 2'b11, 2'b11, 1'b0, 2'd0, 1'b1, 2'd1}, // R2 deny
    '{4'd5,  2'b10, 2'b11, 2'b11, 1'b0, 2'd0, 1'b1, 2'd1}, // R3 reserved
    '{4'd7,  2'b11, 2'b00, 2'b00, 1'b1, 2'd2, 1'b0, 2'd0}, // R4 allow all
    '{4'd7,  2'b01, 2'b00, 2'b00, 1'b0, 2'd0, 1'b1, 2'd2}, // R5 ap none
    '{4'd2,  2'b01, 2'b11, 2'b01, 1'b0, 2'd0, 1'b0, 2'd2}, // R5 priv only
    '{4'd2,  2'b01, 2'b11, 2'b01, 1'b0, 2'd1, 1'b1, 2'd0}, // R5 priv write
    '{4'd9,  2'b01, 2'b11, 2'b10, 1'b0, 2'd0, 1'b0, 2'd0}, // R5 user read
    '{4'd9,  2'b01, 2'b11, 2'b10, 1'b0, 2'd1, 1'b0, 2'd2}, // R5 user write
    '{4'd9,  2'b01, 2'b11, 2'b10, 1'b0, 2'd1, 1'b1, 2'd0}, // R5 priv write
    '{4'd0,  2'b01, 2'b00, 2'b11, 1'b1, 2'd2, 1'b1, 2'd3}, // R6 xn fetch
    '{4'd0,  2'b01, 2'b00, 2'b11, 1'b1, 2'd0, 1'b0, 2'd0}, // R6 xn data
    '{4'd15, 2'b00, 2'b11, 2'b11, 1'b1, 2'd2, 1'b1, 2'd1}, // R8 deny first
    '{4'd4,  2'b01, 2'b11, 2'b00, 1'b1, 2'd2, 1'b1, 2'd3}, // R8 xn before ap
    '{4'd1,  2'b01, 2'b11, 2'b10, 1'b0, 2'd2, 1'b0, 2'd0}, // R7 fetch as read
    '{4'd6,  2'b01, 2'b11, 2'b11, 1'b1, 2'd3, 1'b0, 2'd3}  // R7 rsvd as fetch
  };

  function automatic logic [CTL_W-1:0] mk_ctl(input logic [3:0] dom,
                                              input logic [1:0] mode,
                                              input logic [1:0] other);
    logic [CTL_W-1:0] c;
    for (int d = 0; d < NUM_DOM; d++)
      c[2*d +: 2] = (d == int'(dom)) ? mode : other;
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    valid_i    = 1'b1;
    domain_i   = v.dom;
    ap_i       = v.ap;
    xn_i       = v.xn;
    acc_type_i = v.acc;
    priv_i     = v.priv;
    dacr_i     = mk_ctl(v.dom, v.mode, v.other);
  endtask

  task automatic expect_res(input string req, input vec_t v);
    chk({req, " allow"}, int'(allow_o), int'(v.code == 2'd0));
    chk({req, " fault"}, int'(fault_o), int'(v.code != 2'd0));
    chk({req, " code"},  int'(fault_code_o), int'(v.code));
    chk({req, " R10 dom"}, int'(fault_dom_o), (v.code != 2'd0) ? int'(v.dom) : 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    drive(TBL[0]);
    @(negedge clk);
    chk("R1 allow", int'(allow_o), 0);
    chk("R1 fault", int'(fault_o), 0);
    chk("R1 code", int'(fault_code_o), 0);
    chk("R1 dom", int'(fault_dom_o), 0);
    valid_i = 1'b0;
    rst_ni  = 1'b1;
    @(negedge clk);

    // table walk, one idle cycle between entries
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      valid_i = 1'b0;
      expect_res($sformatf("R2-table[%0d] R8", i), TBL[i]);
      @(negedge clk);
      // R9 single-cycle pulse
      chk("R9 idle allow", int'(allow_o), 0);
      chk("R9 idle fault", int'(fault_o), 0);
      chk("R9 idle code", int'(fault_code_o), 0);
    end

    // R9 back-to-back accesses
    drive(TBL[11]);
    @(negedge clk);
    drive(TBL[12]);
    expect_res("R9 b2b first", TBL[11]);
    @(negedge clk);
    drive(TBL[3]);
    expect_res("R9 b2b second", TBL[12]);
    @(negedge clk);
    valid_i = 1'b0;
    expect_res("R9 b2b third R4", TBL[3]);

    // R2 mode field picked from bits of domain 15 only
    @(negedge clk);
    valid_i    = 1'b1;
    domain_i   = 4'd15;
    ap_i       = 2'b00;
    xn_i       = 1'b1;
    acc_type_i = 2'd2;
    priv_i     = 1'b0;
    dacr_i     = {2'b11, {(CTL_W-2){1'b0}}};
    @(negedge clk);
    valid_i = 1'b0;
    chk("R4 top field allow", int'(allow_o), 1);
    chk("R2 top field code", int'(fault_code_o), 0);

    // R1 reset while a fault result is due
    @(negedge clk);
    drive(TBL[1]);
    #2 rst_ni = 1'b0;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R1 mid-run fault", int'(fault_o), 0);
    chk("R1 mid-run code", int'(fault_code_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    drive(TBL[1]);
    @(negedge clk);
    valid_i = 1'b0;
    expect_res("R2 after reset", TBL[1]);
    @(negedge clk);
    finish_run();
  end

endmodule